// File: doc/BRIEF.md
# Interlocked Four-Phase Read Link

This block pairs a requesting controller with a responding controller. Between them runs a read link that has no shared clock. Each controller runs on its own local clock. The two sides pace each other through two handshake wires, `bus_msyn` from the requester and `bus_ssyn` from the responder. Each side passes the other side's handshake wire through a multi-flop synchronizer before acting on it. The other bus wires (address, memory request, read strobe, data) change only while the handshake protects them, so they are sampled without synchronizers.

A read goes through four events in a fixed order:
1. The requester places the address and raises the request and read strobes.
2. After a programmable setup time, the requester raises `bus_msyn`.
3. The responder sees `bus_msyn`, performs an access of runtime-selectable length on its local read port, drives the data and raises `bus_ssyn`.
4. The requester sees `bus_ssyn`, latches the data and drops every line it drives. The responder sees `bus_msyn` low and drops `bus_ssyn` and the data. A new read can start only after the requester sees `bus_ssyn` low again.

A read therefore takes as long as the two sides need, and its length changes with the responder's latency.

Top module: `async_rd_link`

## Requirements
- R1: After accepting a start, the requester holds `bus_mreq` and `bus_rd` high with the address for exactly ADDR_SETUP requester cycles before `bus_msyn` rises.
- R2: The responder raises `bus_ssyn` only while `bus_msyn` is high. Counting responder falling edges with `bus_msyn` high and `bus_ssyn` low gives a count between `lat`+3 and `lat`+4 (two-stage synchronizer).
- R3: When the requester sees `bus_ssyn` high, it pulses `done` for one cycle. In that same cycle it drives `bus_addr` to 0 and drives `bus_mreq`, `bus_rd` and `bus_msyn` low.
- R4: The responder drops `bus_ssyn` only after `bus_msyn` is low, and drives `bus_data` to 0 whenever `bus_ssyn` is low.
- R5: `busy` stays high from the accepted start until the requester sees `bus_ssyn` low. `bus_msyn` never rises while `bus_ssyn` is high.
- R6: A `start` pulse that arrives while `busy` is high is ignored: no second read takes place and the result is not changed.
- R7: `bus_addr` stays stable for as long as `bus_msyn` is high.
- R8: After reset, all bus lines, `busy`, `done`, `rdata` and `acc_addr` are 0.
- R9: `acc_addr` presents the address of the read. `rdata` holds the value that `acc_rdata` had when the access completed.
- R10: The responder samples `lat` once, when it first sees `bus_msyn`. Later changes to `lat` do not change that read's latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_m | input | 1 | Requester local clock |
| rst_m_n | input | 1 | Requester active-low reset |
| clk_s | input | 1 | Responder local clock |
| rst_s_n | input | 1 | Responder active-low reset |
| start | input | 1 | Request one read (requester domain) |
| start_addr | input | ADDR_W | Address for the requested read |
| busy | output | 1 | Read in progress or link not yet idle |
| done | output | 1 | One-cycle pulse when data is latched |
| rdata | output | DATA_W | Latched read data |
| lat | input | LAT_W | Responder access latency in responder cycles |
| acc_addr | output | ADDR_W | Address presented on the responder's local read port |
| acc_rdata | input | DATA_W | Data returned by the responder's local read port |
| bus_addr | output | ADDR_W | Link address lines |
| bus_mreq | output | 1 | Link memory request strobe |
| bus_rd | output | 1 | Link read strobe |
| bus_msyn | output | 1 | Requester handshake wire |
| bus_ssyn | output | 1 | Responder handshake wire |
| bus_data | output | DATA_W | Link data lines driven by the responder |

## Verification
The bound checker watches the ordering of the handshake on every cycle of both clocks:
- each handshake edge happens only when the other wire has the level it should;
- the address stays stable while `bus_msyn` is high;
- strobes are present before `bus_msyn` rises;
- the lines are released together with `done`;
- `busy` clears only after `bus_ssyn` is low.

Only the bench scenarios can show the rest: the data values, the exact setup count, how the latency window scales across all `lat` values, that `lat` is captured once per read, and that a start arriving during a read is ignored.

// File: rtl/async_rd_pkg.sv
package async_rd_pkg;
   typedef enum logic [1:0] {
      M_IDLE  = 2'd0,
      M_SETUP = 2'd1,
      M_WAIT  = 2'd2,
      M_REL   = 2'd3
   } req_state_t;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_ACC  = 2'd1,
      S_HOLD = 2'd2
   } rsp_state_t;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("hs_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_requester.sv
module hs_requester
   import async_rd_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int ADDR_SETUP  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_mreq,
   output logic              bus_rd,
   output logic              bus_msyn,
   input  logic              bus_ssyn,
   input  logic [DATA_W-1:0] bus_data
);
   localparam int SETUP_W = (ADDR_SETUP < 2) ? 1 : $clog2(ADDR_SETUP);

   generate
      if (ADDR_SETUP < 1) begin : g_bad_setup
         $error("hs_requester: ADDR_SETUP must be at least 1");
      end
   endgenerate

   req_state_t       st;
   logic [SETUP_W-1:0] cnt;
   logic             ssyn_s;

   hs_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_ssyn), .q(ssyn_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= M_IDLE;
         cnt      <= '0;
         done     <= 1'b0;
         rdata    <= '0;
         bus_addr <= '0;
         bus_mreq <= 1'b0;
         bus_rd   <= 1'b0;
         bus_msyn <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            M_IDLE: if (start && !ssyn_s) begin
               bus_addr <= start_addr;
               bus_mreq <= 1'b1;
               bus_rd   <= 1'b1;
               cnt      <= SETUP_W'(ADDR_SETUP - 1);
               st       <= M_SETUP;
            end
            M_SETUP: if (cnt == '0) begin
               bus_msyn <= 1'b1;
               st       <= M_WAIT;
            end else begin
               cnt <= cnt - 1'b1;
            end
            M_WAIT: if (ssyn_s) begin
               rdata    <= bus_data;
               done     <= 1'b1;
               bus_addr <= '0;
               bus_mreq <= 1'b0;
               bus_rd   <= 1'b0;
               bus_msyn <= 1'b0;
               st       <= M_REL;
            end
            M_REL: if (!ssyn_s) st <= M_IDLE;
            default: st <= M_IDLE;
         endcase
      end
   end

   assign busy = (st != M_IDLE);
endmodule

// File: rtl/hs_responder.sv
module hs_responder
   import async_rd_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int LAT_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LAT_W-1:0]  lat,
   output logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_rdata,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_msyn,
   output logic              bus_ssyn,
   output logic [DATA_W-1:0] bus_data
);
   rsp_state_t       st;
   logic [LAT_W-1:0] cnt;
   logic             msyn_s;

   hs_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_msyn), .q(msyn_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         cnt      <= '0;
         acc_addr <= '0;
         bus_ssyn <= 1'b0;
         bus_data <= '0;
      end else begin
         case (st)
            S_IDLE: if (msyn_s) begin
               acc_addr <= bus_addr;
               cnt      <= lat;
               st       <= S_ACC;
            end
            S_ACC: if (cnt == '0) begin
               bus_data <= acc_rdata;
               bus_ssyn <= 1'b1;
               st       <= S_HOLD;
            end else begin
               cnt <= cnt - 1'b1;
            end
            S_HOLD: if (!msyn_s) begin
               bus_ssyn <= 1'b0;
               bus_data <= '0;
               st       <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/async_rd_link.sv
module async_rd_link #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 16,
   parameter int LAT_W       = 4,
   parameter int ADDR_SETUP  = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_m,
   input  logic              rst_m_n,
   input  logic              clk_s,
   input  logic              rst_s_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   input  logic [LAT_W-1:0]  lat,
   output logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] acc_rdata,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_mreq,
   output logic              bus_rd,
   output logic              bus_msyn,
   output logic              bus_ssyn,
   output logic [DATA_W-1:0] bus_data
);
   generate
      if (ADDR_W < 1 || DATA_W < 1 || LAT_W < 1) begin : g_bad_width
         $error("async_rd_link: widths must be positive");
      end
   endgenerate

   hs_requester #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .ADDR_SETUP(ADDR_SETUP), .SYNC_STAGES(SYNC_STAGES)
   ) i_req (
      .clk(clk_m), .rst_n(rst_m_n),
      .start(start), .start_addr(start_addr),
      .busy(busy), .done(done), .rdata(rdata),
      .bus_addr(bus_addr), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
      .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn), .bus_data(bus_data)
   );

   hs_responder #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .LAT_W(LAT_W), .SYNC_STAGES(SYNC_STAGES)
   ) i_rsp (
      .clk(clk_s), .rst_n(rst_s_n),
      .lat(lat), .acc_addr(acc_addr), .acc_rdata(acc_rdata),
      .bus_addr(bus_addr), .bus_msyn(bus_msyn),
      .bus_ssyn(bus_ssyn), .bus_data(bus_data)
   );
endmodule

// File: rtl/async_rd_link_chk.sv
module async_rd_link_chk #(
   parameter int ADDR_W = 8
) (
   input logic              clk_m,
   input logic              rst_m_n,
   input logic              clk_s,
   input logic              rst_s_n,
   input logic              busy,
   input logic              done,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_mreq,
   input logic              bus_rd,
   input logic              bus_msyn,
   input logic              bus_ssyn
);
   // R1: strobes already present in the cycle before bus_msyn rises
   a_r1_strobes_first: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      $rose(bus_msyn) |-> ($past(bus_mreq) && $past(bus_rd)));

   // R2: responder raises its wire only under an active request
   a_r2_ssyn_under_msyn: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      $rose(bus_ssyn) |-> bus_msyn);

   // R3: requester releases only after the responder answered
   a_r3_release_after_ssyn: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      $fell(bus_msyn) |-> bus_ssyn);

   // R3: done coincides with all requester lines low
   a_r3_done_lines_low: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      done |-> (!bus_msyn && !bus_mreq && !bus_rd));

   // R4: responder drops its wire only once the request is gone
   a_r4_ssyn_drop_after_msyn: assert property (@(posedge clk_s) disable iff (!rst_s_n)
      $fell(bus_ssyn) |-> !bus_msyn);

   // R5: no new request while the previous answer is still up
   a_r5_no_overlap: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      $rose(bus_msyn) |-> !bus_ssyn);

   // R5: busy clears only after the answer wire is low
   a_r5_busy_clear: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      $fell(busy) |-> !bus_ssyn);

   // R7: address frozen while the request wire is high
   a_r7_addr_stable: assert property (@(posedge clk_m) disable iff (!rst_m_n)
      (bus_msyn && $past(bus_msyn)) |-> $stable(bus_addr));
endmodule

bind async_rd_link async_rd_link_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
   .busy(busy), .done(done), .bus_addr(bus_addr), .bus_mreq(bus_mreq),
   .bus_rd(bus_rd), .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn)
);

// File: tb/test_async_rd_link.sv
`timescale 1ns/1ps
module test_async_rd_link;
   localparam int CLK_PERIOD   = 10;
   localparam int CLK_S_PERIOD = 14;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int LAT_W  = 4;
   localparam int SETUP  = 2;

   logic clk_m = 0, clk_s = 0, rst_m_n = 0, rst_s_n = 0;
   logic start = 0;
   logic [ADDR_W-1:0] start_addr = '0;
   logic [LAT_W-1:0]  lat = '0;
   logic busy, done, bus_mreq, bus_rd, bus_msyn, bus_ssyn;
   logic [DATA_W-1:0] rdata, bus_data, acc_rdata;
   logic [ADDR_W-1:0] acc_addr, bus_addr;

   int checks = 0, errors = 0;
   int sn = 0, t_m = 0, t_s = 0, mn = 0, t_rq = 0, t_ms = 0, n_done = 0;
   logic pm = 0, ps = 0, pq = 0, pms = 0;

   always #(CLK_PERIOD/2)   clk_m = ~clk_m;
   always #(CLK_S_PERIOD/2) clk_s = ~clk_s;

   function automatic logic [DATA_W-1:0] model(input logic [ADDR_W-1:0] a);
      return {a ^ 8'h3C, a + 8'h51};
   endfunction

   assign acc_rdata = model(acc_addr);

   async_rd_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT_W(LAT_W),
                   .ADDR_SETUP(SETUP), .SYNC_STAGES(2)) i_async_rd_link (
      .clk_m(clk_m), .rst_m_n(rst_m_n), .clk_s(clk_s), .rst_s_n(rst_s_n),
      .start(start), .start_addr(start_addr), .busy(busy), .done(done),
      .rdata(rdata), .lat(lat), .acc_addr(acc_addr), .acc_rdata(acc_rdata),
      .bus_addr(bus_addr), .bus_mreq(bus_mreq), .bus_rd(bus_rd),
      .bus_msyn(bus_msyn), .bus_ssyn(bus_ssyn), .bus_data(bus_data)
   );

   // responder-side edge timestamps
   always @(negedge clk_s) begin
      sn <= sn + 1;
      if (bus_msyn && !pm) t_m <= sn;
      if (bus_ssyn && !ps) t_s <= sn;
      pm <= bus_msyn;
      ps <= bus_ssyn;
   end

   // requester-side edge timestamps
   always @(negedge clk_m) begin
      mn <= mn + 1;
      if (bus_mreq && !pq) t_rq <= mn;
      if (bus_msyn && !pms) t_ms <= mn;
      if (done) n_done <= n_done + 1;
      pq <= bus_mreq;
      pms <= bus_msyn;
   end

   task automatic chk(input string req, input logic ok, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_done();
      for (int i = 0; i < 2000 && !done; i++) @(negedge clk_m);
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000 && busy; i++) @(negedge clk_m);
   endtask

   task automatic issue(input logic [ADDR_W-1:0] a);
      @(negedge clk_m);
      start = 1; start_addr = a;
      @(negedge clk_m);
      start = 0;
   endtask

   task automatic txn(input logic [ADDR_W-1:0] a, input int l);
      int w;
      lat = LAT_W'(l);
      issue(a);
      wait_done();
      chk("R9 rdata", rdata == model(a), rdata, model(a));
      chk("R9 acc_addr", acc_addr == a, acc_addr, a);
      chk("R3 lines released", {bus_msyn, bus_mreq, bus_rd} == 3'b000 && bus_addr == '0,
          {bus_msyn, bus_mreq, bus_rd, bus_addr}, 0);
      chk("R5 busy while ssyn high", busy && bus_ssyn, {busy, bus_ssyn}, 3);
      chk("R1 setup cycles", (t_ms - t_rq) == SETUP, t_ms - t_rq, SETUP);
      w = t_s - t_m;
      chk("R2 latency window", (w >= l + 3) && (w <= l + 4), w, l + 3);
      wait_idle();
      chk("R5 idle after ssyn low", !busy && !bus_ssyn, {busy, bus_ssyn}, 0);
      chk("R4 data cleared", bus_data == '0, bus_data, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk_m);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int w, nd;
      repeat (3) @(negedge clk_m);
      // R8 reset state
      chk("R8 reset bus", {bus_msyn, bus_ssyn, bus_mreq, bus_rd} == 4'b0 && bus_addr == '0
          && bus_data == '0, {bus_msyn, bus_ssyn, bus_mreq, bus_rd}, 0);
      chk("R8 reset outputs", !busy && !done && rdata == '0 && acc_addr == '0, rdata, 0);
      rst_m_n = 1; rst_s_n = 1;
      repeat (4) @(negedge clk_m);

      // exhaustive latency sweep with varied addresses
      for (int l = 0; l < (1 << LAT_W); l++) txn(ADDR_W'(l * 17 + 3), l);
      txn(8'hFF, 1);
      txn(8'h00, 0);

      // R6: start while busy is ignored
      nd = n_done;
      lat = 4'd6;
      issue(8'h42);
      repeat (3) @(negedge clk_m);
      start = 1; start_addr = 8'h99;
      @(negedge clk_m);
      start = 0;
      wait_done();
      wait_idle();
      repeat (40) @(negedge clk_m);
      chk("R6 one read only", (n_done - nd) == 1, n_done - nd, 1);
      chk("R6 result unchanged", rdata == model(8'h42), rdata, model(8'h42));
      chk("R6 link idle", !busy && !bus_msyn && !bus_mreq, {busy, bus_msyn, bus_mreq}, 0);

      // R10: lat changed after the responder captured it
      lat = 4'd9;
      issue(8'h77);
      for (int i = 0; i < 200 && !bus_msyn; i++) @(negedge clk_s);
      repeat (4) @(negedge clk_s);
      lat = 4'd0;
      wait_done();
      w = t_s - t_m;
      chk("R10 latency captured once", (w >= 12) && (w <= 13), w, 12);
      chk("R10 data", rdata == model(8'h77), rdata, model(8'h77));
      wait_idle();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule